// File: doc/BRIEF.md
# Burst-Synchronised Slave Frame Timer

This block produces the per-frame timing of a loop-transceiver slave. It runs from a fast reference clock. It stays idle until a one-cycle burst-received pulse arrives. The pulse opens a frame window, and during that window the block generates three things: a bit clock for two 8-bit voice channels, a pair of complementary channel enables, and a slower clock for two D channels. When the window ends, every clock parks low until the next pulse. Any slip between the master's timing and the local reference is therefore absorbed once per frame.

Inside the window, the block shifts two voice bytes out on one serial line and captures two voice bytes from another. It also exchanges two bits per frame on each of two D-channel lanes. A valid-data flag is captured at the start of each frame. Captured receive words appear on the parallel outputs when a frame completes.

With the default parameters the bit clock is the reference divided by 64, the D clock is the reference divided by 512, and a frame window lasts 1024 reference cycles.

Top module: `slv_frame_timer`

## Requirements
- R1: One reference cycle after a cycle with `burst_rx` high, `en1`, `bclk` and `dclk` are all high.
- R2: Per frame, `bclk` makes exactly 16 periods of 64 reference cycles each, high for the first 32 cycles of each period. It then stays low until the next burst.
- R3: `en2` is always the inverse of `en1`. `en1` is high for the first 512 cycles of the window (the first 8 bit-clock periods) and is low at all other times, including while idle.
- R4: `b_ser_out` presents one bit per rising `bclk` edge, MSB first: the bits of `b_tx_ch1` on rising edges 1 to 8 and the bits of `b_tx_ch2` on rising edges 9 to 16. It is low while idle. Both words are captured on the burst.
- R5: `b_ser_in` is sampled on falling `bclk` edges, MSB first: edges 1 to 8 fill `b_rx_ch1` and edges 9 to 16 fill `b_rx_ch2`. Both words update when the window closes.
- R6: Per frame, `dclk` makes exactly 2 periods of 512 reference cycles each, high for the first half of each period. Every rising edge of `dclk` coincides with a rising edge of `bclk`.
- R7: D lane i transmits `d_tx_word[2i+1]` and then `d_tx_word[2i]` on `d_ser_out[i]`, each bit presented on a rising `dclk` edge. The lane samples `d_ser_in[i]` on falling `dclk` edges into `d_rx_word[2i+1]` and then `d_rx_word[2i]`, and these bits are published at window close.
- R8: `vd_out` takes the value of `vd_in` on a burst and holds that value at all other times.
- R9: A burst arriving inside a window restarts the sequence from the first bit. The receive words of the interrupted window are never published.
- R10: During reset, all clocks, `en1`, the serial outputs, the receive words and `vd_out` are low, and `en2` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_rx | input | 1 | One-cycle pulse: burst from master demodulated |
| vd_in | input | 1 | Valid-data flag, captured on a burst |
| b_tx_ch1 | input | 8 | Voice channel 1 byte to transmit |
| b_tx_ch2 | input | 8 | Voice channel 2 byte to transmit |
| b_ser_in | input | 1 | Serial voice receive data |
| d_tx_word | input | 4 | D lane transmit bits, two per lane |
| d_ser_in | input | 2 | Serial D-channel receive data, one per lane |
| bclk | output | 1 | Gated voice bit clock |
| dclk | output | 1 | Gated D-channel clock |
| en1 | output | 1 | Voice channel 1 enable, frame reference |
| en2 | output | 1 | Voice channel 2 enable, inverse of en1 |
| vd_out | output | 1 | Valid-data flag for this frame |
| b_ser_out | output | 1 | Serial voice transmit data |
| b_rx_ch1 | output | 8 | Received voice channel 1 byte |
| b_rx_ch2 | output | 8 | Received voice channel 2 byte |
| d_ser_out | output | 2 | Serial D-channel transmit data, one per lane |
| d_rx_word | output | 4 | Received D lane bits, two per lane |

## Verification
The transmit and receive paths are run with several byte pairs:
- An alternating pattern and its partner expose bit-order swaps.
- All-ones against all-zeros exposes channels that are swapped or mixed.
- A single set bit at opposite ends of the two bytes exposes off-by-one bit indexing.

The D lanes get different per-lane patterns, so a swap between the lanes shows up. A burst injected 300 cycles into a window distinguishes a true restart from a design that lets the first window finish or that publishes a partly captured receive word. Idle gaps after each frame show whether the clocks park low.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int unsigned SFT_BCLK_DIV = 64;
  localparam int unsigned SFT_CH_BITS  = 8;
  localparam int unsigned SFT_DCLK_DIV = 512;
  localparam int unsigned SFT_D_LANES  = 2;

  function automatic int unsigned sft_frame_len(input int unsigned bdiv,
                                                input int unsigned bits);
    return 2 * bits * bdiv;
  endfunction

  function automatic int unsigned sft_d_bits(input int unsigned bdiv,
                                             input int unsigned bits,
                                             input int unsigned ddiv);
    return (2 * bits * bdiv) / ddiv;
  endfunction

endpackage

// File: rtl/sft_phase_gen.sv
module sft_phase_gen #(
  parameter  int unsigned BDIV = 64,
  parameter  int unsigned BITS = 8,
  parameter  int unsigned DDIV = 512,
  localparam int unsigned FLEN = 2 * BITS * BDIV,
  localparam int unsigned CW   = $clog2(FLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          nx_active,
  output logic [CW-1:0] nx_cnt,
  output logic          frame_done,
  output logic          bclk,
  output logic          dclk,
  output logic          en1
);
  localparam int unsigned BSW = $clog2(BDIV);
  localparam int unsigned DSW = $clog2(DDIV);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_q, dclk_q, en1_q;
  logic          last;

  assign last = act_q && (cnt_q == CW'(FLEN - 1));

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (last) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  assign frame_done = last && !start;
  assign nx_active  = act_d;
  assign nx_cnt     = cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      dclk_q <= 1'b0;
      en1_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      bclk_q <= act_d & ~cnt_d[BSW-1];
      dclk_q <= act_d & ~cnt_d[DSW-1];
      en1_q  <= act_d & (cnt_d < CW'(FLEN / 2));
    end
  end

  assign bclk = bclk_q;
  assign dclk = dclk_q;
  assign en1  = en1_q;

  // rising bit-clock edges counted since the last start
  logic [CW-1:0] chk_rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      chk_rises <= '0;
    else if (start)                                  chk_rises <= CW'(1);
    else if (act_d && !cnt_d[BSW-1] && !bclk_q)      chk_rises <= chk_rises + CW'(1);
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (en1_q && bclk_q && dclk_q)); // R1
  AST_BCLK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    chk_rises <= CW'(2 * BITS)); // R2
  AST_DCLK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_q) |-> $rose(bclk_q)); // R6

endmodule

// File: rtl/sft_lane.sv
module sft_lane #(
  parameter int unsigned W   = 16,
  parameter int unsigned DIV = 64,
  parameter int unsigned CW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          nx_active,
  input  logic [CW-1:0] nx_cnt,
  input  logic          frame_done,
  input  logic [W-1:0]  tx_word,
  input  logic          ser_in,
  output logic          ser_out,
  output logic [W-1:0]  rx_word
);
  localparam int unsigned SW = $clog2(DIV);

  logic [W-1:0]  word_q, word_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [W-1:0]  rx_q, rx_d;
  logic          ser_q, ser_d;
  logic [W-1:0]  cur, shifted;
  logic [SW-1:0] sub;
  logic [CW-1:0] idx;
  logic          smp;

  assign sub     = nx_cnt[SW-1:0];
  assign idx     = nx_cnt >> SW;
  assign cur     = start ? tx_word : word_q;
  assign shifted = cur << idx;
  assign smp     = nx_active && (sub == SW'(DIV / 2));

  always_comb begin
    word_d = cur;
    ser_d  = ser_q;
    if (!nx_active)      ser_d = 1'b0;
    else if (sub == '0)  ser_d = shifted[W-1];
    sh_d = smp ? {sh_q[W-2:0], ser_in} : sh_q;
    rx_d = frame_done ? sh_q : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      ser_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      ser_q  <= ser_d;
    end
  end

  assign ser_out = ser_q;
  assign rx_word = rx_q;

  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nx_active && (nx_cnt[SW-1:0] != '0)) |=> $stable(ser_out)); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_word)); // R9

endmodule

// File: rtl/slv_frame_timer.sv
module slv_frame_timer
  import sft_pkg::*;
#(
  parameter int unsigned BDIV    = SFT_BCLK_DIV,
  parameter int unsigned BITS    = SFT_CH_BITS,
  parameter int unsigned DDIV    = SFT_DCLK_DIV,
  parameter int unsigned D_LANES = SFT_D_LANES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           burst_rx,
  input  logic                           vd_in,
  input  logic [BITS-1:0]                b_tx_ch1,
  input  logic [BITS-1:0]                b_tx_ch2,
  input  logic                           b_ser_in,
  input  logic [D_LANES*sft_d_bits(BDIV,BITS,DDIV)-1:0] d_tx_word,
  input  logic [D_LANES-1:0]             d_ser_in,
  output logic                           bclk,
  output logic                           dclk,
  output logic                           en1,
  output logic                           en2,
  output logic                           vd_out,
  output logic                           b_ser_out,
  output logic [BITS-1:0]                b_rx_ch1,
  output logic [BITS-1:0]                b_rx_ch2,
  output logic [D_LANES-1:0]             d_ser_out,
  output logic [D_LANES*sft_d_bits(BDIV,BITS,DDIV)-1:0] d_rx_word
);
  localparam int unsigned FLEN = sft_frame_len(BDIV, BITS);
  localparam int unsigned CW   = $clog2(FLEN);
  localparam int unsigned DB   = sft_d_bits(BDIV, BITS, DDIV);

  logic          nx_active, frame_done;
  logic [CW-1:0] nx_cnt;
  logic          en1_w;
  logic          vd_q, vd_d;
  logic [2*BITS-1:0] b_rx_w;

  sft_phase_gen #(.BDIV(BDIV), .BITS(BITS), .DDIV(DDIV)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (burst_rx),
    .nx_active  (nx_active),
    .nx_cnt     (nx_cnt),
    .frame_done (frame_done),
    .bclk       (bclk),
    .dclk       (dclk),
    .en1        (en1_w)
  );

  assign en1 = en1_w;
  assign en2 = ~en1_w;

  sft_lane #(.W(2*BITS), .DIV(BDIV), .CW(CW)) u_voice (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (burst_rx),
    .nx_active  (nx_active),
    .nx_cnt     (nx_cnt),
    .frame_done (frame_done),
    .tx_word    ({b_tx_ch1, b_tx_ch2}),
    .ser_in     (b_ser_in),
    .ser_out    (b_ser_out),
    .rx_word    (b_rx_w)
  );

  assign b_rx_ch1 = b_rx_w[2*BITS-1:BITS];
  assign b_rx_ch2 = b_rx_w[BITS-1:0];

  for (genvar gi = 0; gi < D_LANES; gi++) begin : g_dlane
    sft_lane #(.W(DB), .DIV(DDIV), .CW(CW)) u_dlane (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (burst_rx),
      .nx_active  (nx_active),
      .nx_cnt     (nx_cnt),
      .frame_done (frame_done),
      .tx_word    (d_tx_word[gi*DB +: DB]),
      .ser_in     (d_ser_in[gi]),
      .ser_out    (d_ser_out[gi]),
      .rx_word    (d_rx_word[gi*DB +: DB])
    );
  end

  assign vd_d = burst_rx ? vd_in : vd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vd_q <= 1'b0;
    else        vd_q <= vd_d;
  end

  assign vd_out = vd_q;

  AST_VD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_rx |=> $stable(vd_out)); // R8

endmodule

// File: tb/tb_slv_frame_timer.sv
module tb_slv_frame_timer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, burst_rx, vd_in, b_ser_in;
  logic [7:0] b_tx_ch1, b_tx_ch2;
  logic [3:0] d_tx_word;
  logic [1:0] d_ser_in;
  logic       bclk, dclk, en1, en2, vd_out, b_ser_out;
  logic [7:0] b_rx_ch1, b_rx_ch2;
  logic [1:0] d_ser_out;
  logic [3:0] d_rx_word;

  slv_frame_timer dut (
    .clk(clk), .rst_n(rst_n), .burst_rx(burst_rx), .vd_in(vd_in),
    .b_tx_ch1(b_tx_ch1), .b_tx_ch2(b_tx_ch2), .b_ser_in(b_ser_in),
    .d_tx_word(d_tx_word), .d_ser_in(d_ser_in), .bclk(bclk), .dclk(dclk),
    .en1(en1), .en2(en2), .vd_out(vd_out), .b_ser_out(b_ser_out),
    .b_rx_ch1(b_rx_ch1), .b_rx_ch2(b_rx_ch2), .d_ser_out(d_ser_out),
    .d_rx_word(d_rx_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic ser; logic en1; } vexp_t;
  vexp_t      vq[$];
  logic [1:0] dq[$];
  logic       rxq[$];
  logic [1:0] dinq[$];

  int b_rises, d_rises, b_high, d_high, e1_high, en2_bad;
  logic pb = 1'b0, pd = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items at clock edges, drives serial receive data
  always @(negedge clk) begin
    if (rst_n) begin
      if (bclk && !pb) begin
        b_rises++;
        if (vq.size() == 0) chk("R2 unexpected bclk rise", 1, 0);
        else begin
          vexp_t e;
          e = vq.pop_front();
          chk("R4 voice tx bit", {31'd0, b_ser_out}, {31'd0, e.ser});
          chk("R3 en1 at bclk rise", {31'd0, en1}, {31'd0, e.en1});
        end
        b_ser_in = (rxq.size() != 0) ? rxq.pop_front() : 1'b0;
      end
      if (dclk && !pd) begin
        d_rises++;
        if (dq.size() == 0) chk("R6 unexpected dclk rise", 1, 0);
        else chk("R7 D tx bits", {30'd0, d_ser_out}, {30'd0, dq.pop_front()});
        d_ser_in = (dinq.size() != 0) ? dinq.pop_front() : 2'b00;
      end
      if (bclk) b_high++;
      if (dclk) d_high++;
      if (en1)  e1_high++;
      if (en2 !== ~en1) en2_bad++;
    end
    pb = bclk;
    pd = dclk;
  end

  task automatic clr_counts();
    b_rises = 0; d_rises = 0; b_high = 0; d_high = 0; e1_high = 0; en2_bad = 0;
  endtask

  task automatic pulse();
    @(negedge clk) burst_rx = 1'b1;
    @(negedge clk) burst_rx = 1'b0;
  endtask

  // driver: pushes expected items for a full frame
  task automatic push_frame(input logic [7:0] t1, input logic [7:0] t2,
                            input logic [7:0] r1, input logic [7:0] r2,
                            input logic [3:0] dt, input logic [3:0] dr, input int nb, input int nd);
    for (int k = 0; k < nb; k++) begin
      vexp_t e;
      e.ser = (k < 8) ? t1[7-k] : t2[15-k];
      e.en1 = (k < 8);
      vq.push_back(e);
      rxq.push_back((k < 8) ? r1[7-k] : r2[15-k]);
    end
    for (int j = 0; j < nd; j++) begin
      dq.push_back(j == 0 ? {dt[3], dt[1]} : {dt[2], dt[0]});
      dinq.push_back(j == 0 ? {dr[3], dr[1]} : {dr[2], dr[0]});
    end
  endtask

  task automatic run_frame(input logic [7:0] t1, input logic [7:0] t2,
                           input logic [7:0] r1, input logic [7:0] r2,
                           input logic [3:0] dt, input logic [3:0] dr, input logic vd);
    push_frame(t1, t2, r1, r2, dt, dr, 16, 2);
    b_tx_ch1 = t1; b_tx_ch2 = t2; d_tx_word = dt; vd_in = vd;
    clr_counts();
    pulse();
    chk("R1 clocks and en1 open", {29'd0, bclk, dclk, en1}, 32'h7);
    repeat (100) @(negedge clk);
    vd_in = ~vd;
    chk("R8 vd held mid frame", {31'd0, vd_out}, {31'd0, vd});
    repeat (930) @(negedge clk);
    chk("R5 rx ch1", {24'd0, b_rx_ch1}, {24'd0, r1});
    chk("R5 rx ch2", {24'd0, b_rx_ch2}, {24'd0, r2});
    chk("R7 D rx", {28'd0, d_rx_word}, {28'd0, dr});
    chk("R2 bclk rises", b_rises, 16);
    chk("R2 bclk high cycles", b_high, 512);
    chk("R6 dclk rises", d_rises, 2);
    chk("R6 dclk high cycles", d_high, 512);
    chk("R3 en1 high cycles", e1_high, 512);
    chk("R3 en2 inverse", en2_bad, 0);
    chk("R8 vd captured", {31'd0, vd_out}, {31'd0, vd});
    chk("R4 queues drained", vq.size() + dq.size(), 0);
    clr_counts();
    repeat (100) @(negedge clk);
    chk("R2 idle parked", {26'd0, b_rises[1:0], d_rises[1:0], bclk, dclk}, 0);
    chk("R4 idle outputs low", {29'd0, b_ser_out, d_ser_out}, 0);
    chk("R3 idle enables", {30'd0, en1, en2}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=timeout exp=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; burst_rx = 1'b0; vd_in = 1'b0; b_ser_in = 1'b0;
    b_tx_ch1 = '0; b_tx_ch2 = '0; d_tx_word = '0; d_ser_in = '0;
    clr_counts();
    repeat (4) @(negedge clk);
    chk("R10 reset clocks/enables", {27'd0, bclk, dclk, en1, en2, vd_out}, 32'h2);
    chk("R10 reset data", {4'd0, b_ser_out, d_ser_out, b_rx_ch1, b_rx_ch2, d_rx_word}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_frame(8'hA5, 8'h3C, 8'h5A, 8'hC3, 4'b1001, 4'b0110, 1'b1);
    run_frame(8'hFF, 8'h00, 8'h00, 8'hFF, 4'b0110, 4'b1001, 1'b0);
    run_frame(8'h01, 8'h80, 8'h80, 8'h01, 4'b1100, 4'b0011, 1'b1);
    run_frame(8'h6E, 8'hD1, 8'h2B, 8'h94, 4'b0011, 4'b1110, 1'b0);

    // R9: restart 300 cycles into a window
    push_frame(8'hF0, 8'h0F, 8'h11, 8'h22, 4'b1111, 4'b1111, 5, 1);
    push_frame(8'h96, 8'h69, 8'hE7, 8'h18, 4'b0101, 4'b1010, 16, 2);
    b_tx_ch1 = 8'hF0; b_tx_ch2 = 8'h0F; d_tx_word = 4'b1111; vd_in = 1'b1;
    clr_counts();
    pulse();
    repeat (299) @(negedge clk);
    b_tx_ch1 = 8'h96; b_tx_ch2 = 8'h69; d_tx_word = 4'b0101; vd_in = 1'b0;
    chk("R9 no publish before restart", {16'd0, b_rx_ch1, b_rx_ch2}, 32'h2B94);
    pulse();
    chk("R9 restart keeps clocks open", {30'd0, bclk, en1}, 32'h3);
    repeat (600) @(negedge clk);
    chk("R9 old rx kept mid restart", {16'd0, b_rx_ch1, b_rx_ch2}, 32'h2B94);
    chk("R9 vd from restart burst", {31'd0, vd_out}, 0);
    repeat (430) @(negedge clk);
    chk("R9 rx from restarted frame", {16'd0, b_rx_ch1, b_rx_ch2}, 32'hE718);
    chk("R9 D rx from restarted frame", {28'd0, d_rx_word}, 32'hA);
    chk("R9 total bclk rises", b_rises, 21);
    chk("R9 total dclk rises", d_rises, 3);
    chk("R9 queues drained", vq.size() + dq.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule